// File: doc/BRIEF.md
# Audio Sample Format Converter

This block turns a little-endian byte stream into 24-bit DSP words, or the reverse, for one transfer at a time. The transfer starts with a pulse on `start`. That pulse captures a direction, a 3-bit format code and a sample count. In the inbound direction (`dir` = 0) bytes enter on the byte input stream and words leave on the word output stream. In the outbound direction (`dir` = 1) words enter on the word input stream and bytes leave on the byte output stream. Every stream uses a valid/ready handshake.

Each format fixes how bits move between the two sides:

- 8-bit samples invert the sign bit. Outbound, they are rounded to nearest with saturation.
- 16-bit samples keep the upper two bytes of the word.
- The two padded 24-bit layouts differ only in where the pad byte sits.
- The 32-bit format spreads each sample over two words.

Before any data moves, the block checks the format code and the count. If either is unusable, it raises `skip` and the whole transfer is dropped. Once every sample has moved, `done` pulses for one cycle.

Top module: `sample_codec`

## Requirements
- R1: While the block is in reset, and whenever no transfer is active, `busy`, `skip`, `done`, `bi_ready`, `wi_ready`, `wo_valid` and `bo_valid` are all low.
- R2: A `start` with format code 4, 5 or 7 is rejected. `skip` is high for exactly the one cycle after the start edge, `busy` stays low, and no handshake completes on any stream.
- R3: A `start` with format 0 and a count that is not a multiple of 4 is rejected in the same way as R2. So is format 1 with an odd count.
- R4: Format 0 inbound takes one byte per word. The word is {inverted byte bit 7, byte bits 6:0} in bits 23:16, and bits 15:0 are zero.
- R5: Format 0 outbound writes one byte per word. The byte is word bits 23:16 plus word bit 15. A positive word whose sum would pass 0x7F is held at 0x7F. Bit 7 of the result is then inverted.
- R6: Format 1 uses two bytes per word, the first byte arriving first. Inbound, bytes b0,b1 give {b1,b0,8'h00}. Outbound, the bytes are word[15:8] and then word[23:16], and word[7:0] is dropped.
- R7: Format 2 uses four bytes per word. Inbound, the first byte is a pad and is ignored, and bytes b1,b2,b3 give {b3,b2,b1}. Outbound, the first byte is 0x00, followed by word[7:0], word[15:8] and word[23:16].
- R8: Format 6 uses four bytes per word. Inbound, bytes b0,b1,b2 give {b2,b1,b0} and the fourth byte is ignored. Outbound, the bytes are word[7:0], word[15:8], word[23:16] and then 0x00.
- R9: Format 3 moves two words per sample as four bytes. Inbound, bytes b0..b3 give a first word {b0,16'h0000} and a second word {b3,b2,b1}. Outbound, the bytes are first-word[23:16] and then the second word's three bytes, low byte first.
- R10: `count` is the number of samples. `done` pulses for one cycle in the cycle after the last output handshake of the transfer, and `busy` falls at the same time. A count of zero with a legal format gives a `done` pulse in the cycle after `start`, with no data.
- R11: An output held back by its ready signal keeps its valid high and its data stable. Backpressure loses no data and does not reorder it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a transfer; ignored while busy |
| dir | input | 1 | 0 = bytes to words, 1 = words to bytes |
| fmt | input | 3 | Sample format code |
| count | input | COUNT_W | Number of samples |
| busy | output | 1 | Transfer in progress |
| skip | output | 1 | One-cycle pulse: transfer rejected |
| done | output | 1 | One-cycle pulse: transfer finished |
| bi_valid | input | 1 | Byte input valid |
| bi_ready | output | 1 | Byte input ready |
| bi_data | input | 8 | Byte input data |
| wo_valid | output | 1 | Word output valid |
| wo_ready | input | 1 | Word output ready |
| wo_data | output | 24 | Word output data |
| wi_valid | input | 1 | Word input valid |
| wi_ready | output | 1 | Word input ready |
| wi_data | input | 24 | Word input data |
| bo_valid | output | 1 | Byte output valid |
| bo_ready | input | 1 | Byte output ready |
| bo_data | output | 8 | Byte output data |

## Verification
A lane counter or phase bit that slips shows up on the very next output. A word gets bytes from the wrong positions, or the 32-bit format puts its two halves in swapped order, and this appears as soon as the first sample completes. A remaining-sample counter that is off by one shows up at the end of the transfer: `done` arrives one sample early or late, or the engine hangs waiting for data that never comes. A wrong acceptance decision shows on `skip` one cycle after `start`, before any data has moved.

// File: rtl/codec_pkg.sv
package codec_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 24;
  localparam int LANES  = 4;
  localparam int GRP_W  = BYTE_W * LANES;

  localparam logic [2:0] FMT_B8    = 3'd0;
  localparam logic [2:0] FMT_B16   = 3'd1;
  localparam logic [2:0] FMT_PADHI = 3'd2;
  localparam logic [2:0] FMT_SPLIT = 3'd3;
  localparam logic [2:0] FMT_PADLO = 3'd6;

  function automatic logic fmt_legal(input logic [2:0] f);
    return (f == FMT_B8) || (f == FMT_B16) || (f == FMT_PADHI) ||
           (f == FMT_SPLIT) || (f == FMT_PADLO);
  endfunction

  // index of the last byte lane of one sample
  function automatic logic [1:0] last_lane(input logic [2:0] f);
    case (f)
      FMT_B8:  return 2'd0;
      FMT_B16: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  // index of the last word of one sample
  function automatic logic last_word(input logic [2:0] f);
    return f == FMT_SPLIT;
  endfunction

  function automatic logic [WORD_W-1:0] grp_to_word(input logic [2:0] f,
                                                    input logic [GRP_W-1:0] g,
                                                    input logic sel);
    case (f)
      FMT_B8:    return {~g[7], g[6:0], 16'h0000};
      FMT_B16:   return {g[15:0], 8'h00};
      FMT_PADHI: return g[31:8];
      FMT_PADLO: return g[23:0];
      FMT_SPLIT: return sel ? g[31:8] : {g[7:0], 16'h0000};
      default:   return '0;
    endcase
  endfunction

  // round to nearest on bit 15, clamp positive overflow, flip sign bit
  function automatic logic [BYTE_W-1:0] round_u8(input logic [WORD_W-1:0] w);
    logic [8:0] s;
    logic [7:0] r;
    s = {w[23], w[23:16]} + {8'h00, w[15]};
    r = (!w[23] && s[7]) ? 8'h7F : s[7:0];
    return {~r[7], r[6:0]};
  endfunction

  function automatic logic [GRP_W-1:0] words_to_grp(input logic [2:0] f,
                                                    input logic [WORD_W-1:0] w0,
                                                    input logic [WORD_W-1:0] w1);
    case (f)
      FMT_B8:    return {24'h000000, round_u8(w0)};
      FMT_B16:   return {16'h0000, w0[23:8]};
      FMT_PADHI: return {w0, 8'h00};
      FMT_PADLO: return {8'h00, w0};
      FMT_SPLIT: return {w1, w0[23:16]};
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/codec_ctl.sv
module codec_ctl #(
  parameter int COUNT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dir_i,
  input  logic [2:0]         fmt_i,
  input  logic [COUNT_W-1:0] count_i,
  input  logic               sample_done,
  output logic               busy,
  output logic               skip,
  output logic               done,
  output logic               dir_q,
  output logic [2:0]         fmt_q,
  output logic               clr
);
  import codec_pkg::*;

  logic               busy_d, skip_d, done_d, dir_d;
  logic [2:0]         fmt_d;
  logic [COUNT_W-1:0] rem_q, rem_d;
  logic               fits, accept;

  always_comb begin
    fits = fmt_legal(fmt_i) &&
           !((fmt_i == FMT_B8)  && (count_i[1:0] != 2'b00)) &&
           !((fmt_i == FMT_B16) && count_i[0]);
    accept = start && !busy;
    clr    = accept;
    busy_d = busy;
    rem_d  = rem_q;
    dir_d  = dir_q;
    fmt_d  = fmt_q;
    skip_d = 1'b0;
    done_d = 1'b0;
    if (accept) begin
      if (!fits) begin
        skip_d = 1'b1;
      end else if (count_i == '0) begin
        done_d = 1'b1;
      end else begin
        busy_d = 1'b1;
        rem_d  = count_i;
        dir_d  = dir_i;
        fmt_d  = fmt_i;
      end
    end else if (busy && sample_done) begin
      rem_d = rem_q - 1'b1;
      if (rem_q == COUNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      skip  <= 1'b0;
      done  <= 1'b0;
      dir_q <= 1'b0;
      fmt_q <= 3'd0;
      rem_q <= '0;
    end else begin
      busy  <= busy_d;
      skip  <= skip_d;
      done  <= done_d;
      dir_q <= dir_d;
      fmt_q <= fmt_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/codec_unpack.sv
module codec_unpack (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         clr,
  input  logic [2:0]                   fmt,
  input  logic                         bi_valid,
  output logic                         bi_ready,
  input  logic [codec_pkg::BYTE_W-1:0] bi_data,
  output logic                         wo_valid,
  input  logic                         wo_ready,
  output logic [codec_pkg::WORD_W-1:0] wo_data,
  output logic                         sample_done
);
  import codec_pkg::*;

  logic             emit_q, emit_d;
  logic [1:0]       lane_q, lane_d;
  logic             wsel_q, wsel_d;
  logic [GRP_W-1:0] grp_q, grp_d;

  always_comb begin
    emit_d      = emit_q;
    lane_d      = lane_q;
    wsel_d      = wsel_q;
    grp_d       = grp_q;
    sample_done = 1'b0;
    bi_ready    = en && !emit_q;
    wo_valid    = en && emit_q;
    wo_data     = grp_to_word(fmt, grp_q, wsel_q);
    if (clr) begin
      emit_d = 1'b0;
      lane_d = 2'd0;
      wsel_d = 1'b0;
    end else if (bi_ready && bi_valid) begin
      grp_d[{lane_q, 3'b000} +: BYTE_W] = bi_data;
      if (lane_q == last_lane(fmt)) begin
        emit_d = 1'b1;
        lane_d = 2'd0;
        wsel_d = 1'b0;
      end else begin
        lane_d = lane_q + 2'd1;
      end
    end else if (wo_valid && wo_ready) begin
      if (wsel_q == last_word(fmt)) begin
        emit_d      = 1'b0;
        sample_done = 1'b1;
      end else begin
        wsel_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit_q <= 1'b0;
      lane_q <= 2'd0;
      wsel_q <= 1'b0;
      grp_q  <= '0;
    end else begin
      emit_q <= emit_d;
      lane_q <= lane_d;
      wsel_q <= wsel_d;
      grp_q  <= grp_d;
    end
  end
endmodule

// File: rtl/codec_pack.sv
module codec_pack (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         clr,
  input  logic [2:0]                   fmt,
  input  logic                         wi_valid,
  output logic                         wi_ready,
  input  logic [codec_pkg::WORD_W-1:0] wi_data,
  output logic                         bo_valid,
  input  logic                         bo_ready,
  output logic [codec_pkg::BYTE_W-1:0] bo_data,
  output logic                         sample_done
);
  import codec_pkg::*;

  logic              emit_q, emit_d;
  logic [1:0]        lane_q, lane_d;
  logic              wsel_q, wsel_d;
  logic [WORD_W-1:0] w0_q, w0_d, w1_q, w1_d;
  logic [GRP_W-1:0]  grp;

  always_comb begin
    emit_d      = emit_q;
    lane_d      = lane_q;
    wsel_d      = wsel_q;
    w0_d        = w0_q;
    w1_d        = w1_q;
    sample_done = 1'b0;
    grp         = words_to_grp(fmt, w0_q, w1_q);
    wi_ready    = en && !emit_q;
    bo_valid    = en && emit_q;
    bo_data     = grp[{lane_q, 3'b000} +: BYTE_W];
    if (clr) begin
      emit_d = 1'b0;
      lane_d = 2'd0;
      wsel_d = 1'b0;
    end else if (wi_ready && wi_valid) begin
      if (wsel_q) w1_d = wi_data;
      else        w0_d = wi_data;
      if (wsel_q == last_word(fmt)) begin
        emit_d = 1'b1;
        wsel_d = 1'b0;
        lane_d = 2'd0;
      end else begin
        wsel_d = 1'b1;
      end
    end else if (bo_valid && bo_ready) begin
      if (lane_q == last_lane(fmt)) begin
        emit_d      = 1'b0;
        sample_done = 1'b1;
      end else begin
        lane_d = lane_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit_q <= 1'b0;
      lane_q <= 2'd0;
      wsel_q <= 1'b0;
      w0_q   <= '0;
      w1_q   <= '0;
    end else begin
      emit_q <= emit_d;
      lane_q <= lane_d;
      wsel_q <= wsel_d;
      w0_q   <= w0_d;
      w1_q   <= w1_d;
    end
  end
endmodule

// File: rtl/sample_codec.sv
module sample_codec #(
  parameter int COUNT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dir,
  input  logic [2:0]         fmt,
  input  logic [COUNT_W-1:0] count,
  output logic               busy,
  output logic               skip,
  output logic               done,
  input  logic               bi_valid,
  output logic               bi_ready,
  input  logic [7:0]         bi_data,
  output logic               wo_valid,
  input  logic               wo_ready,
  output logic [23:0]        wo_data,
  input  logic               wi_valid,
  output logic               wi_ready,
  input  logic [23:0]        wi_data,
  output logic               bo_valid,
  input  logic               bo_ready,
  output logic [7:0]         bo_data
);
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  logic       dir_q, clr, in_done, out_done;
  logic [2:0] fmt_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  codec_ctl #(.COUNT_W(COUNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_sn), .start(start), .dir_i(dir), .fmt_i(fmt),
    .count_i(count), .sample_done(in_done | out_done), .busy(busy),
    .skip(skip), .done(done), .dir_q(dir_q), .fmt_q(fmt_q), .clr(clr)
  );

  codec_unpack u_unpack (
    .clk(clk), .rst_n(rst_sn), .en(busy && !dir_q), .clr(clr), .fmt(fmt_q),
    .bi_valid(bi_valid), .bi_ready(bi_ready), .bi_data(bi_data),
    .wo_valid(wo_valid), .wo_ready(wo_ready), .wo_data(wo_data),
    .sample_done(in_done)
  );

  codec_pack u_pack (
    .clk(clk), .rst_n(rst_sn), .en(busy && dir_q), .clr(clr), .fmt(fmt_q),
    .wi_valid(wi_valid), .wi_ready(wi_ready), .wi_data(wi_data),
    .bo_valid(bo_valid), .bo_ready(bo_ready), .bo_data(bo_data),
    .sample_done(out_done)
  );
endmodule

// File: rtl/sample_codec_chk.sv
module sample_codec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        skip,
  input logic        done,
  input logic        bi_ready,
  input logic        wi_ready,
  input logic        wo_valid,
  input logic        wo_ready,
  input logic [23:0] wo_data,
  input logic        bo_valid,
  input logic        bo_ready,
  input logic [7:0]  bo_data,
  input logic [2:0]  fmt_q
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bi_ready || wi_ready || wo_valid || bo_valid));

  p_skip_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (!busy && !done));

  p_skip_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> !skip);

  p_b8_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wo_valid && fmt_q == 3'd0) |-> (wo_data[15:0] == 16'h0000));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !skip));

  p_one_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wo_valid && bo_valid));

  p_wo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wo_valid && !wo_ready) |=> (wo_valid && $stable(wo_data)));

  p_bo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_valid && !bo_ready) |=> (bo_valid && $stable(bo_data)));
endmodule

bind sample_codec sample_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .skip(skip), .done(done),
  .bi_ready(bi_ready), .wi_ready(wi_ready), .wo_valid(wo_valid),
  .wo_ready(wo_ready), .wo_data(wo_data), .bo_valid(bo_valid),
  .bo_ready(bo_ready), .bo_data(bo_data), .fmt_q(fmt_q)
);

// File: tb/sample_codec_bench.sv
module sample_codec_bench;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst_n, start, dir;
  logic [2:0] fmt;
  logic [CW-1:0] count;
  logic busy, skip, done;
  logic bi_valid, bi_ready, wo_valid, wo_ready, wi_valid, wi_ready, bo_valid, bo_ready;
  logic [7:0]  bi_data, bo_data;
  logic [23:0] wo_data, wi_data;

  int tests = 0;
  int fails = 0;

  logic [7:0]  byt [16];
  logic [23:0] wrd [16];

  always #2.5 clk = ~clk;

  sample_codec #(.COUNT_W(CW)) u_sample_codec (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .fmt(fmt), .count(count),
    .busy(busy), .skip(skip), .done(done),
    .bi_valid(bi_valid), .bi_ready(bi_ready), .bi_data(bi_data),
    .wo_valid(wo_valid), .wo_ready(wo_ready), .wo_data(wo_data),
    .wi_valid(wi_valid), .wi_ready(wi_ready), .wi_data(wi_data),
    .bo_valid(bo_valid), .bo_ready(bo_ready), .bo_data(bo_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic kick(input logic d, input logic [2:0] f, input int n);
    @(negedge clk);
    start = 1'b1; dir = d; fmt = f; count = CW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  // bytes in byt[0..nb-1] go in, words wrd[0..nw-1] are expected out
  task automatic run_in(input string req, input logic [2:0] f, input int n,
                        input int nb, input int nw, input bit stall);
    kick(1'b0, f, n);
    chk({req, " busy"}, 32'(busy), 32'd1);
    fork
      begin
        for (int i = 0; i < nb; i++) begin
          bi_valid = 1'b1; bi_data = byt[i];
          while (!bi_ready) @(negedge clk);
          @(negedge clk);
        end
        bi_valid = 1'b0;
      end
      begin
        int k = 0;
        while (k < nw) begin
          wo_ready = stall ? ~wo_ready : 1'b1;
          if (wo_valid && wo_ready) begin
            chk({req, " word"}, 32'(wo_data), 32'(wrd[k]));
            k++;
          end
          @(negedge clk);
        end
      end
    join
    wo_ready = 1'b1;
    chk({req, " R10 done"}, {busy, done}, 2'b01);
  endtask

  // words wrd[0..nw-1] go in, bytes byt[0..nb-1] are expected out
  task automatic run_out(input string req, input logic [2:0] f, input int n,
                         input int nw, input int nb, input bit stall);
    kick(1'b1, f, n);
    chk({req, " busy"}, 32'(busy), 32'd1);
    fork
      begin
        for (int i = 0; i < nw; i++) begin
          wi_valid = 1'b1; wi_data = wrd[i];
          while (!wi_ready) @(negedge clk);
          @(negedge clk);
        end
        wi_valid = 1'b0;
      end
      begin
        int k = 0;
        while (k < nb) begin
          bo_ready = stall ? ~bo_ready : 1'b1;
          if (bo_valid && bo_ready) begin
            chk({req, " byte"}, 32'(bo_data), 32'(byt[k]));
            k++;
          end
          @(negedge clk);
        end
      end
    join
    bo_ready = 1'b1;
    chk({req, " R10 done"}, {busy, done}, 2'b01);
  endtask

  task automatic run_skip(input string req, input logic d, input logic [2:0] f, input int n);
    kick(d, f, n);
    chk({req, " skip/busy/done"}, {skip, busy, done}, 3'b100);
    bi_valid = 1'b1; wi_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk({req, " no movement"}, {bi_ready, wi_ready, wo_valid, bo_valid, skip}, 5'b0);
    end
    bi_valid = 1'b0; wi_valid = 1'b0;
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    #1;
    chk("R1 reset outputs", {busy, skip, done, bi_ready, wi_ready, wo_valid, bo_valid}, 7'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle outputs", {busy, skip, done, bi_ready, wi_ready, wo_valid, bo_valid}, 7'b0);
  endtask

  task automatic test_b8;
    byt[0:3] = '{8'h12, 8'h34, 8'h56, 8'h78};
    wrd[0:3] = '{24'h920000, 24'hB40000, 24'hD60000, 24'hF80000};
    run_in("R4 b8 in", 3'd0, 4, 4, 4, 1'b0);
    wrd[0:3] = '{24'h927FFF, 24'hB48000, 24'h7E8000, 24'h800000};
    byt[0:3] = '{8'h12, 8'h35, 8'hFF, 8'h00};
    run_out("R5 b8 out", 3'd0, 4, 4, 4, 1'b0);
    wrd[0:3] = '{24'h7FFFFF, 24'h7E7FFF, 24'hFF8000, 24'h000000};
    byt[0:3] = '{8'hFF, 8'hFE, 8'h80, 8'h80};
    run_out("R5 b8 sat", 3'd0, 4, 4, 4, 1'b0);
  endtask

  task automatic test_b16;
    byt[0:3] = '{8'h34, 8'h12, 8'hCD, 8'hAB};
    wrd[0:1] = '{24'h123400, 24'hABCD00};
    run_in("R6 b16 in", 3'd1, 2, 4, 2, 1'b0);
    wrd[0:1] = '{24'h1234FF, 24'hABCD00};
    run_out("R6 b16 out", 3'd1, 2, 2, 4, 1'b0);
  endtask

  task automatic test_pad;
    byt[0:3] = '{8'hFF, 8'h56, 8'h34, 8'h12};
    wrd[0] = 24'h123456;
    run_in("R7 padhi in", 3'd2, 1, 4, 1, 1'b0);
    byt[0:3] = '{8'h00, 8'h56, 8'h34, 8'h12};
    run_out("R7 padhi out", 3'd2, 1, 1, 4, 1'b0);
    byt[0:3] = '{8'h56, 8'h34, 8'h12, 8'hFF};
    run_in("R8 padlo in", 3'd6, 1, 4, 1, 1'b0);
    byt[0:3] = '{8'h56, 8'h34, 8'h12, 8'h00};
    run_out("R8 padlo out", 3'd6, 1, 1, 4, 1'b0);
  endtask

  task automatic test_split;
    byt[0:7] = '{8'h12, 8'hBC, 8'h9A, 8'h78, 8'hAA, 8'h01, 8'h02, 8'h03};
    wrd[0:3] = '{24'h120000, 24'h789ABC, 24'hAA0000, 24'h030201};
    run_in("R9 split in", 3'd3, 2, 8, 4, 1'b0);
    wrd[0:3] = '{24'h12FFFF, 24'h789ABC, 24'hAA0000, 24'h030201};
    run_out("R9 split out", 3'd3, 2, 4, 8, 1'b0);
  endtask

  task automatic test_reject;
    run_skip("R2 fmt4", 1'b0, 3'd4, 4);
    run_skip("R2 fmt5", 1'b1, 3'd5, 4);
    run_skip("R2 fmt7", 1'b0, 3'd7, 4);
    run_skip("R3 b8 count6", 1'b0, 3'd0, 6);
    run_skip("R3 b16 count3", 1'b1, 3'd1, 3);
  endtask

  task automatic test_zero;
    kick(1'b0, 3'd2, 0);
    chk("R10 zero count", {skip, busy, done}, 3'b001);
    @(negedge clk);
    chk("R10 zero count after", {skip, busy, done, bi_ready}, 4'b0);
  endtask

  task automatic test_stall;
    byt[0:7] = '{8'h01, 8'h80, 8'hFF, 8'h7F, 8'h10, 8'h20, 8'h30, 8'h40};
    wrd[0:3] = '{24'h800100, 24'h7FFF00, 24'h201000, 24'h403000};
    run_in("R11 stall in", 3'd1, 4, 8, 4, 1'b1);
    wrd[0:1] = '{24'hC00000, 24'h654321};
    byt[0:3] = '{8'hC0, 8'h21, 8'h43, 8'h65};
    run_out("R11 stall out", 3'd3, 1, 2, 4, 1'b1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: all requirements actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    start = 1'b0; dir = 1'b0; fmt = 3'd0; count = '0;
    bi_valid = 1'b0; bi_data = '0; wi_valid = 1'b0; wi_data = '0;
    wo_ready = 1'b1; bo_ready = 1'b1;
    test_reset;
    test_b8;
    test_b16;
    test_pad;
    test_split;
    test_reject;
    test_zero;
    test_stall;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule